// File: doc/BRIEF.md
# Ping-Pong Bulk OUT Endpoint Controller

This block holds the receive-side control and status for one bulk OUT endpoint of a USB device. It sits behind a simplified protocol layer, which delivers decoded events as one-cycle strobes: an OUT token, received data bytes, end of packet with a CRC verdict, a host protocol violation and a Clear Feature request. For each transaction the block chooses a handshake (ACK, NAK or STALL) and stores accepted payloads in one of two packet buffers. The two buffers are used in alternation.

On the processor side there is an 8-bit control/status register, a byte read port and an interrupt request. The status bits describe only the buffer that is currently active. Writing one to the packet-complete bit releases that buffer and moves the view to the other one. The interrupt can follow a DMA-style threshold: it asserts once fewer than a set number of bytes are left in the active buffer. A force-stall request takes effect at the next point where no transaction is in progress. At that moment it hands over to a sent-stall flag.

Top module: `usb_out_pingpong`

## Requirements
- R1: After an OUT token and up to 64 data bytes (zero bytes included), an end-of-packet strobe with CRC good stores the packet and raises hs_vld for exactly one cycle, starting the cycle after the strobe, with hs_sel = 1 (ACK). hs_sel codes: 0 none, 1 ACK, 2 NAK, 3 STALL.
- R2: A packet whose CRC is bad, or that carries more than 64 bytes, gets no handshake (hs_vld stays 0) and leaves the status and the buffer contents unchanged.
- R3: When both buffers hold unread packets, an OUT token is answered with NAK (hs_sel = 2) and its data is dropped.
- R4: Status bit 1 (packet complete) reads 1 while the active buffer holds a packet. Writing 1 to it releases that buffer and makes the other buffer active, and the status is recomputed for the new buffer. If the other buffer also holds a packet, bit 1 stays 1.
- R5: Status bit 6 (receive not empty) reads 1 while the active buffer still has unread bytes. It reads 0 once they are all read, and it reads 0 for a zero-length packet.
- R6: Status bit 0 (receive service) reads 1 while either buffer holds a packet that is not fully read. A zero-length packet counts as unread until it is released. The bit reads 0 once every stored byte has been read.
- R7: rd_data shows the next unread byte of the active buffer. A one-cycle rd_en advances to the following byte in arrival order. rd_en has no effect while bit 6 is 0.
- R8: With status bit 3 (DMA enable) at 0, irq = irq_en AND bit 1 AND "no byte of the active packet has been read yet".
- R9: With bit 3 at 1, irq = irq_en AND bit 1 AND "fewer than 32 bytes remain unread in the active buffer". Exactly 32 remaining gives irq = 0.
- R10: Bit 3 is read/write. Bit 2 and bit 7 always read 0.
- R11: Status bit 5 (force stall) is read/write. While it is set, OUT tokens get STALL (hs_sel = 3). Entry into the stall state waits until no transaction is in progress. On entry, bit 4 (sent stall) becomes 1 and bit 5 becomes 0.
- R12: Writing 1 to bit 4 clears it, but the stall continues until a Clear Feature strobe. After that, tokens are accepted again unless bit 5 is written to 1 again.
- R13: A protocol-violation strobe makes OUT tokens get STALL without setting bit 4. Clear Feature ends this stall. Data already buffered stays readable through either kind of stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tok_out | input | 1 | OUT token strobe, starts a transaction |
| rx_byte_vld | input | 1 | Data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_eop |
| proto_err | input | 1 | Host protocol violation strobe |
| clr_feature | input | 1 | Clear Feature (endpoint halt) strobe |
| hs_vld | output | 1 | Handshake request, one cycle |
| hs_sel | output | 2 | Handshake code: 1 ACK, 2 NAK, 3 STALL |
| csr_wr | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Write data for the register |
| csr_rdata | output | 8 | Current register value |
| rd_en | input | 1 | Pop one byte from the active buffer |
| rd_data | output | 8 | Next unread byte of the active buffer |
| irq_en | input | 1 | Receive interrupt enable |
| irq | output | 1 | Receive interrupt request |

## Verification
On every cycle, the assertions check these rules: a handshake appears only right after an end of packet; a buffer is never written into while it is full; a read pointer never passes its packet length; clearing packet-complete reloads it when the other buffer is full; receive-not-empty implies receive-service; the interrupt implies packet-complete; the stall state holds until Clear Feature, is never entered in the middle of a transaction, and sets sent-stall only by clearing force-stall. Some behaviour shows only in the bench scenarios: the order of handshakes over a run of packets, the byte order and content on the read port, the exact 32/31 byte boundary of the DMA threshold, and the fact that data survives both stall kinds.

// File: rtl/usbep_pkg.sv
package usbep_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef enum logic [1:0] {
    XM_IDLE  = 2'd0,
    XM_TAKE  = 2'd1,
    XM_NAK   = 2'd2,
    XM_STALL = 2'd3
  } xmode_e;

  localparam int unsigned F_RFS = 0;
  localparam int unsigned F_PC  = 1;
  localparam int unsigned F_RSV = 2;
  localparam int unsigned F_DME = 3;
  localparam int unsigned F_SST = 4;
  localparam int unsigned F_FST = 5;
  localparam int unsigned F_RNE = 6;

endpackage

// File: rtl/usbep_buf.sv
module usbep_buf #(
  parameter int unsigned PKT_MAX = 64,
  localparam int unsigned AW = $clog2(PKT_MAX),
  localparam int unsigned CW = $clog2(PKT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  input  logic          release_i,
  input  logic          pop,
  output logic          full,
  output logic [CW-1:0] len,
  output logic [CW-1:0] rptr,
  output logic [7:0]    head
);

  logic [7:0]    mem [PKT_MAX];
  logic          full_q, full_d;
  logic [CW-1:0] len_q, len_d;
  logic [CW-1:0] rptr_q, rptr_d;
  logic          pop_ok;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign pop_ok = pop && full_q && (rptr_q < len_q);

  always_comb begin
    full_d = full_q;
    len_d  = len_q;
    rptr_d = rptr_q;
    if (release_i) begin
      full_d = 1'b0;
      rptr_d = '0;
    end else if (commit && !full_q) begin
      full_d = 1'b1;
      len_d  = commit_len;
      rptr_d = '0;
    end else if (pop_ok) begin
      rptr_d = rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      len_q  <= '0;
      rptr_q <= '0;
    end else begin
      full_q <= full_d;
      len_q  <= len_d;
      rptr_q <= rptr_d;
    end
  end

  assign full = full_q;
  assign len  = len_q;
  assign rptr = rptr_q;
  assign head = mem[rptr_q[AW-1:0]];

  // R2: a buffer holding a packet is never overwritten by a new one
  a_r2_commit_free: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !full_q);

  // R7: reading never runs past the stored length
  a_r7_ptr_within: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (rptr_q <= len_q));

endmodule

// File: rtl/usbep_rxctl.sv
module usbep_rxctl
  import usbep_pkg::*;
#(
  parameter int unsigned PKT_MAX = 64,
  localparam int unsigned AW = $clog2(PKT_MAX),
  localparam int unsigned CW = $clog2(PKT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_out,
  input  logic          rx_byte_vld,
  input  logic [7:0]    rx_byte,
  input  logic          rx_eop,
  input  logic          rx_crc_ok,
  input  logic          stall_req,
  input  logic          tgt_full,
  output logic          in_xfer,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit,
  output logic [CW-1:0] commit_len,
  output logic          hs_vld,
  output logic [1:0]    hs_sel
);

  localparam logic [CW-1:0] MAXC = CW'(PKT_MAX);

  xmode_e        mode_q, mode_d;
  logic [CW-1:0] bcnt_q, bcnt_d;
  logic          ovf_q, ovf_d;
  logic          hsv_q, hsv_d;
  hs_e           hss_q, hss_d;

  always_comb begin
    mode_d = mode_q;
    bcnt_d = bcnt_q;
    ovf_d  = ovf_q;
    hsv_d  = 1'b0;
    hss_d  = hss_q;
    wr_en  = 1'b0;
    commit = 1'b0;
    if (tok_out) begin
      if (stall_req)     mode_d = XM_STALL;
      else if (tgt_full) mode_d = XM_NAK;
      else               mode_d = XM_TAKE;
      bcnt_d = '0;
      ovf_d  = 1'b0;
    end else if (mode_q != XM_IDLE) begin
      if (rx_eop) begin
        mode_d = XM_IDLE;
        if (rx_crc_ok && !ovf_q) begin
          hsv_d = 1'b1;
          case (mode_q)
            XM_TAKE: hss_d = HS_ACK;
            XM_NAK:  hss_d = HS_NAK;
            default: hss_d = HS_STALL;
          endcase
          commit = (mode_q == XM_TAKE);
        end
      end else if (rx_byte_vld) begin
        if (bcnt_q < MAXC) begin
          bcnt_d = bcnt_q + 1'b1;
          wr_en  = (mode_q == XM_TAKE);
        end else begin
          ovf_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= XM_IDLE;
      bcnt_q <= '0;
      ovf_q  <= 1'b0;
      hsv_q  <= 1'b0;
      hss_q  <= HS_NONE;
    end else begin
      mode_q <= mode_d;
      bcnt_q <= bcnt_d;
      ovf_q  <= ovf_d;
      hsv_q  <= hsv_d;
      hss_q  <= hss_d;
    end
  end

  assign in_xfer    = (mode_q != XM_IDLE);
  assign wr_addr    = bcnt_q[AW-1:0];
  assign wr_data    = rx_byte;
  assign commit_len = bcnt_q;
  assign hs_vld     = hsv_q;
  assign hs_sel     = hss_q;

  // R1: a handshake is only ever issued right after an end of packet
  a_r1_hs_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    hsv_q |-> $past(rx_eop));

  // R2: bad CRC at the close of a transaction yields no handshake
  a_r2_no_hs_bad_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop && !rx_crc_ok && !tok_out) |=> !hsv_q);

endmodule

// File: rtl/usbep_stall.sv
module usbep_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic fst_wr,
  input  logic fst_wval,
  input  logic sst_w1c,
  input  logic in_xfer,
  input  logic proto_err,
  input  logic clr_feature,
  output logic fst,
  output logic sst,
  output logic stall_req
);

  logic fst_q, fst_d;
  logic sst_q, sst_d;
  logic hold_q, hold_d;
  logic auto_q, auto_d;
  logic enter;

  assign enter = fst_q && !in_xfer && !hold_q;

  always_comb begin
    fst_d  = fst_wr ? fst_wval : fst_q;
    sst_d  = sst_q & ~sst_w1c;
    hold_d = hold_q;
    auto_d = auto_q | proto_err;
    if (enter) begin
      hold_d = 1'b1;
      sst_d  = 1'b1;
      fst_d  = 1'b0;
    end
    if (clr_feature) begin
      hold_d = 1'b0;
      auto_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst_q  <= 1'b0;
      sst_q  <= 1'b0;
      hold_q <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      fst_q  <= fst_d;
      sst_q  <= sst_d;
      hold_q <= hold_d;
      auto_q <= auto_d;
    end
  end

  assign fst       = fst_q;
  assign sst       = sst_q;
  assign stall_req = hold_q | auto_q | fst_q;

  // R11: sent-stall rises only together with the stall hand-off
  a_r11_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sst_q) && !$past(clr_feature)) |-> (!fst_q && hold_q));

  // R11: the forced stall is never entered mid-transaction
  a_r11_defer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> !$past(in_xfer));

  // R12: only Clear Feature ends a forced stall
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !clr_feature) |=> hold_q);

endmodule

// File: rtl/usb_out_pingpong.sv
module usb_out_pingpong
  import usbep_pkg::*;
#(
  parameter int unsigned PKT_MAX = 64,
  parameter int unsigned DMA_THR = 32,
  localparam int unsigned AW = $clog2(PKT_MAX),
  localparam int unsigned CW = $clog2(PKT_MAX + 1),
  localparam int unsigned NBUF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_out,
  input  logic       rx_byte_vld,
  input  logic [7:0] rx_byte,
  input  logic       rx_eop,
  input  logic       rx_crc_ok,
  input  logic       proto_err,
  input  logic       clr_feature,
  output logic       hs_vld,
  output logic [1:0] hs_sel,
  input  logic       csr_wr,
  input  logic [7:0] csr_wdata,
  output logic [7:0] csr_rdata,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       irq_en,
  output logic       irq
);

  localparam logic [CW-1:0] THR = CW'(DMA_THR);

  logic          rs1_q, rs2_q;
  logic          srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  logic          act_q, act_d;
  logic          wsel_q, wsel_d;
  logic          dme_q, dme_d;

  logic [NBUF-1:0] full_w, rel_w, pop_w, wen_w, cmt_w;
  logic [CW-1:0]   len_w  [NBUF];
  logic [CW-1:0]   rptr_w [NBUF];
  logic [7:0]      head_w [NBUF];

  logic          rx_wen, rx_commit, in_xfer, stall_req;
  logic [AW-1:0] rx_waddr;
  logic [7:0]    rx_wdata;
  logic [CW-1:0] rx_len;
  logic          fst, sst;

  logic          pc, rne, rfs, pc_clr;
  logic [CW-1:0] remain;

  usbep_rxctl #(.PKT_MAX(PKT_MAX)) u_rx (
    .clk        (clk),
    .rst_n      (srst_n),
    .tok_out    (tok_out),
    .rx_byte_vld(rx_byte_vld),
    .rx_byte    (rx_byte),
    .rx_eop     (rx_eop),
    .rx_crc_ok  (rx_crc_ok),
    .stall_req  (stall_req),
    .tgt_full   (full_w[wsel_q]),
    .in_xfer    (in_xfer),
    .wr_en      (rx_wen),
    .wr_addr    (rx_waddr),
    .wr_data    (rx_wdata),
    .commit     (rx_commit),
    .commit_len (rx_len),
    .hs_vld     (hs_vld),
    .hs_sel     (hs_sel)
  );

  usbep_stall u_stall (
    .clk        (clk),
    .rst_n      (srst_n),
    .fst_wr     (csr_wr),
    .fst_wval   (csr_wdata[F_FST]),
    .sst_w1c    (csr_wr & csr_wdata[F_SST]),
    .in_xfer    (in_xfer),
    .proto_err  (proto_err),
    .clr_feature(clr_feature),
    .fst        (fst),
    .sst        (sst),
    .stall_req  (stall_req)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    assign wen_w[b] = rx_wen    && (wsel_q == 1'(b));
    assign cmt_w[b] = rx_commit && (wsel_q == 1'(b));
    assign rel_w[b] = pc_clr    && (act_q  == 1'(b));
    assign pop_w[b] = rd_en && rne && !pc_clr && (act_q == 1'(b));

    usbep_buf #(.PKT_MAX(PKT_MAX)) u_buf (
      .clk       (clk),
      .rst_n     (srst_n),
      .wr_en     (wen_w[b]),
      .wr_addr   (rx_waddr),
      .wr_data   (rx_wdata),
      .commit    (cmt_w[b]),
      .commit_len(rx_len),
      .release_i (rel_w[b]),
      .pop       (pop_w[b]),
      .full      (full_w[b]),
      .len       (len_w[b]),
      .rptr      (rptr_w[b]),
      .head      (head_w[b])
    );
  end

  always_comb begin
    rfs = 1'b0;
    for (int b = 0; b < NBUF; b++) begin
      if (full_w[b] && !((len_w[b] != '0) && (rptr_w[b] == len_w[b]))) begin
        rfs = 1'b1;
      end
    end
  end

  assign pc     = full_w[act_q];
  assign rne    = pc && (rptr_w[act_q] < len_w[act_q]);
  assign pc_clr = csr_wr && csr_wdata[F_PC] && pc;
  assign remain = len_w[act_q] - rptr_w[act_q];

  always_comb begin
    act_d  = pc_clr    ? ~act_q  : act_q;
    wsel_d = rx_commit ? ~wsel_q : wsel_q;
    dme_d  = csr_wr    ? csr_wdata[F_DME] : dme_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      act_q  <= 1'b0;
      wsel_q <= 1'b0;
      dme_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      wsel_q <= wsel_d;
      dme_q  <= dme_d;
    end
  end

  always_comb begin
    csr_rdata        = '0;
    csr_rdata[F_RFS] = rfs;
    csr_rdata[F_PC]  = pc;
    csr_rdata[F_DME] = dme_q;
    csr_rdata[F_SST] = sst;
    csr_rdata[F_FST] = fst;
    csr_rdata[F_RNE] = rne;
  end

  assign rd_data = head_w[act_q];
  assign irq = irq_en && pc &&
               (dme_q ? (remain < THR) : (rptr_w[act_q] == '0));

  // R4: releasing the active buffer reloads packet-complete from the other
  a_r4_pc_reload: assert property (@(posedge clk) disable iff (!srst_n)
    (pc_clr && full_w[~act_q]) |=> csr_rdata[F_PC]);

  // R6: unread bytes in the active buffer imply receive-service
  a_r6_rne_in_rfs: assert property (@(posedge clk) disable iff (!srst_n)
    csr_rdata[F_RNE] |-> csr_rdata[F_RFS]);

  // R8: the receive interrupt only ever accompanies packet-complete
  a_r8_irq_needs_pc: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> csr_rdata[F_PC]);

endmodule

// File: tb/usb_out_pingpong_bench.sv
`timescale 1ns/1ps
module usb_out_pingpong_bench;

  logic       clk, rst_n;
  logic       tok_out, rx_byte_vld, rx_eop, rx_crc_ok, proto_err, clr_feature;
  logic [7:0] rx_byte;
  logic       hs_vld;
  logic [1:0] hs_sel;
  logic       csr_wr;
  logic [7:0] csr_wdata, csr_rdata;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       irq_en, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  usb_out_pingpong u_usb_out_pingpong (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_byte_vld(rx_byte_vld),
    .rx_byte(rx_byte), .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
    .proto_err(proto_err), .clr_feature(clr_feature), .hs_vld(hs_vld),
    .hs_sel(hs_sel), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .rd_en(rd_en), .rd_data(rd_data),
    .irq_en(irq_en), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {clear_pc_first, len[6:0], crc_ok, exp_hs[1:0], exp_csr[7:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 7'd5,  1'b1, 2'd1, 8'h43},
    {1'b0, 7'd7,  1'b0, 2'd0, 8'h43},
    {1'b0, 7'd64, 1'b1, 2'd1, 8'h43},
    {1'b0, 7'd3,  1'b1, 2'd2, 8'h43},
    {1'b1, 7'd0,  1'b1, 2'd1, 8'h43},
    {1'b1, 7'd2,  1'b1, 2'd1, 8'h03},
    {1'b1, 7'd65, 1'b1, 2'd0, 8'h43},
    {1'b1, 7'd1,  1'b1, 2'd1, 8'h43}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic start_tok();
    @(negedge clk); tok_out = 1'b1;
    @(negedge clk); tok_out = 1'b0;
  endtask

  task automatic finish_pkt(input int n, input bit crc, input logic [7:0] base,
                            output logic [1:0] code);
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1'b1; rx_byte = base + 8'(i);
      @(negedge clk);
    end
    rx_byte_vld = 1'b0; rx_eop = 1'b1; rx_crc_ok = crc;
    @(negedge clk);
    rx_eop = 1'b0; rx_crc_ok = 1'b0;
    code = hs_vld ? hs_sel : 2'd0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_pkt(input int n, input bit crc, input logic [7:0] base,
                          output logic [1:0] code);
    start_tok();
    finish_pkt(n, crc, base, code);
  endtask

  task automatic csr_write(input logic [7:0] v);
    @(negedge clk); csr_wr = 1'b1; csr_wdata = v;
    @(negedge clk); csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_feature = 1'b1;
    @(negedge clk); clr_feature = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [1:0] code;
    rst_n = 1'b0; tok_out = 0; rx_byte_vld = 0; rx_byte = 0; rx_eop = 0;
    rx_crc_ok = 0; proto_err = 0; clr_feature = 0; csr_wr = 0; csr_wdata = 0;
    rd_en = 0; irq_en = 0;
    do_reset();

    // reset state (R4 R6 R10)
    chk("R4 reset csr", csr_rdata, 8'h00);
    chk("R1 reset hs", hs_vld, 1'b0);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][18]) csr_write(8'h02);
      send_pkt(int'(VEC[v][17:11]), VEC[v][10], 8'(v * 16), code);
      chk($sformatf("R1/R2/R3 vec%0d handshake", v), code, VEC[v][9:8]);
      chk($sformatf("R4/R5/R6 vec%0d csr", v), csr_rdata, VEC[v][7:0]);
    end

    // read port and interrupt thresholds
    do_reset();
    irq_en = 1'b1;
    send_pkt(4, 1'b1, 8'h10, code);
    chk("R1 pkt A ack", code, 2'd1);
    send_pkt(40, 1'b1, 8'h80, code);
    chk("R1 pkt B ack", code, 2'd1);
    chk("R8 irq before any read", irq, 1'b1);
    chk("R7 first byte", rd_data, 8'h10);
    pop();
    chk("R7 second byte", rd_data, 8'h11);
    chk("R8 irq after partial read", irq, 1'b0);
    csr_write(8'h08);
    chk("R9 irq dme 3 left", irq, 1'b1);
    for (int i = 1; i < 4; i++) begin
      chk("R7 byte order A", rd_data, 8'h10 + 8'(i));
      pop();
    end
    chk("R5 R6 A drained, B unread", csr_rdata, 8'h0B);
    pop();
    csr_write(8'h0A);
    chk("R4 advance to B", csr_rdata, 8'h4B);
    chk("R7 pop ignored when empty", rd_data, 8'h80);
    chk("R9 irq 40 left", irq, 1'b0);
    for (int i = 0; i < 8; i++) pop();
    chk("R9 irq exactly 32 left", irq, 1'b0);
    pop();
    chk("R9 irq 31 left", irq, 1'b1);
    for (int i = 9; i < 39; i++) pop();
    chk("R7 last byte B", rd_data, 8'hA7);
    pop();
    chk("R6 all drained", csr_rdata, 8'h0A);
    csr_write(8'h0A);
    chk("R4 both released", csr_rdata, 8'h08);
    csr_write(8'h04);
    chk("R10 reserved bit and dme clear", csr_rdata, 8'h00);

    // forced stall handoff
    start_tok();
    csr_write(8'h20);
    chk("R11 fst pending during transaction", csr_rdata, 8'h20);
    finish_pkt(2, 1'b1, 8'h55, code);
    chk("R11 in-flight packet still acked", code, 2'd1);
    chk("R11 sst set fst cleared", csr_rdata, 8'h53);
    send_pkt(1, 1'b1, 8'h01, code);
    chk("R11 token stalled", code, 2'd3);
    csr_write(8'h10);
    chk("R12 sst w1c", csr_rdata, 8'h43);
    send_pkt(1, 1'b1, 8'h01, code);
    chk("R12 still stalled after sst clear", code, 2'd3);
    pulse_clr();
    send_pkt(3, 1'b1, 8'h60, code);
    chk("R12 accepted after clear feature", code, 2'd1);
    chk("R12 buffered data intact", rd_data, 8'h55);

    // automatic stall
    @(negedge clk); proto_err = 1'b1;
    @(negedge clk); proto_err = 1'b0;
    send_pkt(1, 1'b1, 8'h01, code);
    chk("R13 auto stall", code, 2'd3);
    chk("R13 no sst on auto stall", csr_rdata, 8'h43);
    pulse_clr();
    send_pkt(1, 1'b1, 8'h01, code);
    chk("R3 nak both full", code, 2'd2);
    csr_write(8'h02);
    chk("R13 second buffer intact", rd_data, 8'h60);
    send_pkt(2, 1'b1, 8'h70, code);
    chk("R13 accept after auto stall cleared", code, 2'd1);

    summary();
  end

endmodule